// File: doc/BRIEF.md
# Shared Odd-Multiple Coefficient Multiplier

This block forms the product of a signed sample and a programmable unsigned coefficient without a general-purpose multiplier. A small bank computes the odd multiples of the sample, 1X to 15X, once per cycle. Every 4-bit slice of the coefficient (an "alphabet") reuses that bank. Each slice picks one odd multiple and shifts it left to rebuild its own partial product. The partial products are moved to their slice weight and added to give the full product.

The block is the multiplier of a single filter tap. A sample and coefficient come in with a valid strobe. The exact product appears on the output one clock later, together with its own valid flag. Widths, the slice width and the style of the final adder are parameters. Two adder styles can be chosen: a serial chain, or a balanced tree.

Top module: `csm_mult`

## Requirements
- R1: The coefficient is cut into 4-bit slices. Slice j is bits [4j+3:4j] and carries weight 2^(4j). So for a 16-bit coefficient the slice in bits 15:12 is weighted 2^12, and coefficient 0xADB6 gives the slices 0xA, 0xD, 0xB and 0x6 from top to bottom.
- R2: Each slice product equals slice value times the sample. A non-zero slice takes the odd multiple (slice >> t)·X and shifts it left by t, where t is the count of trailing zeros in the slice. For example, slice 10 becomes 5X shifted by one. A zero slice contributes zero.
- R3: prod_o equals the sample, read as 16-bit two's complement, times the coefficient, read as 16-bit unsigned. The result is 32-bit two's complement and is exact for every input pair.
- R4: When valid_i is high at a rising edge, valid_o is high after that edge. prod_o then carries the product of the x_i and coef_i sampled at that edge, so the latency is one clock.
- R5: When valid_i is low at a rising edge, valid_o is low after it and prod_o keeps its previous value, whatever x_i and coef_i are.
- R6: While rst_n is low, valid_o is 0 and prod_o is 0.
- R7: The extreme operands give exact results. These are X = -32768 or 32767 with coefficient 0xFFFF, and a zero sample or zero coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample and coefficient are valid this cycle |
| x_i | input | 16 | Sample, two's complement |
| coef_i | input | 16 | Coefficient, unsigned |
| valid_o | output | 1 | prod_o holds a new product |
| prod_o | output | 32 | Registered product, two's complement |

## Verification
Every product is due exactly one clock after the edge that accepted its valid_i. The driver applies stimulus on falling edges and queues the expected product at the same time. The monitor also works on falling edges. Each time it sees valid_o, it takes the oldest queued value and compares, so a result that comes a cycle early or late, or not at all, shows up as a mismatch or as an item left in the queue. In cycles with valid_o low, the monitor checks that prod_o still equals the last product, while the driver puts random values on x_i and coef_i.

// File: rtl/csm_pkg.sv
package csm_pkg;
   typedef enum logic {
      SUM_CHAIN = 1'b0,
      SUM_TREE  = 1'b1
   } sum_style_e;
endpackage

// File: rtl/csm_odd_bank.sv
// Shared bank of odd multiples 1X,3X,...,(2^A-1)X built from shift-add only.
module csm_odd_bank #(
   parameter int DATA_W  = 16,
   parameter int ALPHA_W = 4,
   localparam int MW     = DATA_W + ALPHA_W,
   localparam int NUM_ODD = 1 << (ALPHA_W - 1)
) (
   input  logic [DATA_W-1:0]            x,
   output logic [NUM_ODD-1:0][MW-1:0]   odd_mul
);
   logic [MW-1:0] x_ext;
   assign x_ext = {{ALPHA_W{x[DATA_W-1]}}, x};

   for (genvar i = 0; i < NUM_ODD; i++) begin : g_odd
      localparam int K = 2 * i + 1;
      logic [MW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int b = 0; b < ALPHA_W; b++) begin
            if (((K >> b) & 1) == 1) acc = acc + (x_ext << b);
         end
      end
      assign odd_mul[i] = acc;
   end
endmodule

// File: rtl/csm_alpha_ctrl.sv
// Decodes one slice into a zero flag, shift amount and odd-multiple index.
module csm_alpha_ctrl #(
   parameter int ALPHA_W = 4,
   localparam int TZW    = (ALPHA_W > 2) ? $clog2(ALPHA_W) : 1,
   localparam int IDXW   = ALPHA_W - 1
) (
   input  logic [ALPHA_W-1:0] alpha,
   output logic               nz,
   output logic [TZW-1:0]     shamt,
   output logic [IDXW-1:0]    idx
);
   logic [ALPHA_W-1:0] odd_val;
   logic               found;

   always_comb begin
      shamt = '0;
      found = 1'b0;
      for (int b = 0; b < ALPHA_W; b++) begin
         if (!found && alpha[b]) begin
            shamt = TZW'(b);
            found = 1'b1;
         end
      end
      odd_val = alpha >> shamt;
      idx     = odd_val[ALPHA_W-1:1];
      nz      = found;
   end
endmodule

// File: rtl/csm_alpha_pick.sv
// Selects one odd multiple from the shared bank and shifts it into place.
module csm_alpha_pick #(
   parameter int DATA_W  = 16,
   parameter int ALPHA_W = 4,
   localparam int MW     = DATA_W + ALPHA_W,
   localparam int NUM_ODD = 1 << (ALPHA_W - 1),
   localparam int TZW    = (ALPHA_W > 2) ? $clog2(ALPHA_W) : 1,
   localparam int IDXW   = ALPHA_W - 1
) (
   input  logic [NUM_ODD-1:0][MW-1:0] odd_mul,
   input  logic                       nz,
   input  logic [TZW-1:0]             shamt,
   input  logic [IDXW-1:0]            idx,
   output logic [MW-1:0]              prod
);
   logic [MW-1:0] picked;
   assign picked = nz ? odd_mul[idx] : '0;
   assign prod   = picked << shamt;
endmodule

// File: rtl/csm_align_sum.sv
// Sign-extends each slice product, moves it to its slice weight and adds.
module csm_align_sum #(
   parameter int NUM_ALPHA = 4,
   parameter int ALPHA_W   = 4,
   parameter int MW        = 20,
   parameter int PROD_W    = 32,
   parameter csm_pkg::sum_style_e SUM_STYLE = csm_pkg::SUM_TREE,
   localparam int PAD      = PROD_W - MW
) (
   input  logic [NUM_ALPHA-1:0][MW-1:0] terms,
   output logic [PROD_W-1:0]            sum
);
   logic [PROD_W-1:0] ext [NUM_ALPHA];

   for (genvar j = 0; j < NUM_ALPHA; j++) begin : g_ext
      assign ext[j] = {{PAD{terms[j][MW-1]}}, terms[j]} << (j * ALPHA_W);
   end

   if (SUM_STYLE == csm_pkg::SUM_CHAIN) begin : g_chain
      logic [PROD_W-1:0] acc [NUM_ALPHA];
      assign acc[0] = ext[0];
      for (genvar j = 1; j < NUM_ALPHA; j++) begin : g_step
         assign acc[j] = acc[j-1] + ext[j];
      end
      assign sum = acc[NUM_ALPHA-1];
   end else begin : g_tree
      localparam int NODES = 2 * NUM_ALPHA - 1;
      logic [PROD_W-1:0] node [NODES];
      for (genvar k = 0; k < NUM_ALPHA; k++) begin : g_leaf
         assign node[NUM_ALPHA-1+k] = ext[k];
      end
      for (genvar i = 0; i < NUM_ALPHA - 1; i++) begin : g_inner
         assign node[i] = node[2*i+1] + node[2*i+2];
      end
      assign sum = node[0];
   end
endmodule

// File: rtl/csm_mult.sv
module csm_mult #(
   parameter int DATA_W  = 16,
   parameter int COEF_W  = 16,
   parameter int ALPHA_W = 4,
   parameter csm_pkg::sum_style_e SUM_STYLE = csm_pkg::SUM_TREE,
   localparam int PROD_W = DATA_W + COEF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [COEF_W-1:0] coef_i,
   output logic              valid_o,
   output logic [PROD_W-1:0] prod_o
);
   localparam int NUM_ALPHA = COEF_W / ALPHA_W;
   localparam int MW        = DATA_W + ALPHA_W;
   localparam int NUM_ODD   = 1 << (ALPHA_W - 1);
   localparam int TZW       = (ALPHA_W > 2) ? $clog2(ALPHA_W) : 1;
   localparam int IDXW      = ALPHA_W - 1;

   if (ALPHA_W < 2) begin : g_bad_alpha
      $error("csm_mult: ALPHA_W must be at least 2");
   end
   if (COEF_W % ALPHA_W != 0) begin : g_bad_split
      $error("csm_mult: COEF_W must be a multiple of ALPHA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("csm_mult: DATA_W must be at least 2");
   end

   logic [NUM_ODD-1:0][MW-1:0]   odd_mul;
   logic [NUM_ALPHA-1:0][MW-1:0] alpha_prod;
   logic [PROD_W-1:0]            sum;

   csm_odd_bank #(.DATA_W(DATA_W), .ALPHA_W(ALPHA_W)) u_bank (
      .x       (x_i),
      .odd_mul (odd_mul)
   );

   for (genvar j = 0; j < NUM_ALPHA; j++) begin : g_alpha
      logic            nz;
      logic [TZW-1:0]  shamt;
      logic [IDXW-1:0] idx;

      csm_alpha_ctrl #(.ALPHA_W(ALPHA_W)) u_ctrl (
         .alpha (coef_i[j*ALPHA_W +: ALPHA_W]),
         .nz    (nz),
         .shamt (shamt),
         .idx   (idx)
      );

      csm_alpha_pick #(.DATA_W(DATA_W), .ALPHA_W(ALPHA_W)) u_pick (
         .odd_mul (odd_mul),
         .nz      (nz),
         .shamt   (shamt),
         .idx     (idx),
         .prod    (alpha_prod[j])
      );
   end

   csm_align_sum #(
      .NUM_ALPHA (NUM_ALPHA),
      .ALPHA_W   (ALPHA_W),
      .MW        (MW),
      .PROD_W    (PROD_W),
      .SUM_STYLE (SUM_STYLE)
   ) u_sum (
      .terms (alpha_prod),
      .sum   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         prod_o  <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) prod_o <= sum;
      end
   end
endmodule

// File: rtl/csm_mult_chk.sv
module csm_mult_chk #(
   parameter int DATA_W  = 16,
   parameter int COEF_W  = 16,
   parameter int ALPHA_W = 4,
   localparam int PROD_W    = DATA_W + COEF_W,
   localparam int NUM_ALPHA = COEF_W / ALPHA_W,
   localparam int MW        = DATA_W + ALPHA_W
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         valid_i,
   input logic [DATA_W-1:0]            x_i,
   input logic [COEF_W-1:0]            coef_i,
   input logic                         valid_o,
   input logic [PROD_W-1:0]            prod_o,
   input logic [NUM_ALPHA-1:0][MW-1:0] alpha_prod
);
   logic [PROD_W-1:0] x_wide, c_wide, ref_prod;
   assign x_wide   = {{COEF_W{x_i[DATA_W-1]}}, x_i};
   assign c_wide   = {{DATA_W{1'b0}}, coef_i};
   assign ref_prod = x_wide * c_wide;

   assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> prod_o == $past(ref_prod));

   assert_valid_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);

   assert_valid_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !valid_o);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(prod_o));

   assert_reset_R6: assert property (@(posedge clk)
      !rst_n |=> (!valid_o && prod_o == '0));

   // R1 slice position and R2 slice product, per slice
   for (genvar j = 0; j < NUM_ALPHA; j++) begin : g_slice
      logic [MW-1:0] xe, ae, ref_slice;
      assign xe        = {{ALPHA_W{x_i[DATA_W-1]}}, x_i};
      assign ae        = {{DATA_W{1'b0}}, coef_i[j*ALPHA_W +: ALPHA_W]};
      assign ref_slice = xe * ae;

      assert_alpha_prod_R2: assert property (@(posedge clk) disable iff (!rst_n)
         alpha_prod[j] == ref_slice);
   end
endmodule

bind csm_mult csm_mult_chk #(
   .DATA_W  (DATA_W),
   .COEF_W  (COEF_W),
   .ALPHA_W (ALPHA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_i    (valid_i),
   .x_i        (x_i),
   .coef_i     (coef_i),
   .valid_o    (valid_o),
   .prod_o     (prod_o),
   .alpha_prod (alpha_prod)
);

// File: tb/csm_mult_test.sv
`timescale 1ns/1ps
module csm_mult_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [15:0] x_i = '0;
   logic [15:0] coef_i = '0;
   logic        valid_o;
   logic [31:0] prod_o;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] last_prod = '0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   csm_mult uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (valid_i),
      .x_i     (x_i),
      .coef_i  (coef_i),
      .valid_o (valid_o),
      .prod_o  (prod_o)
   );

   function automatic logic [31:0] ref_mul(input logic [15:0] x, input logic [15:0] c);
      longint p;
      p = longint'($signed(x)) * longint'({16'b0, c});
      return p[31:0];
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] x, input logic [15:0] c, input string req);
      @(negedge clk);
      x_i = x;
      coef_i = c;
      valid_i = 1'b1;
      exp_q.push_back(ref_mul(x, c));
      tag_q.push_back(req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         valid_i = 1'b0;
         x_i = 16'($urandom);
         coef_i = 16'($urandom);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // monitor: one cycle latency, sampled at falling edges
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (valid_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected valid_o", prod_o, 32'h0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(prod_o === e, t, prod_o, e);
            end
            last_prod = prod_o;
         end else begin
            check(prod_o === last_prod, "R5 hold while idle", prod_o, last_prod);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'h0, 32'h0);
      summary();
      $finish;
   end

   initial begin
      // R6 reset state
      repeat (3) @(negedge clk);
      check(valid_o === 1'b0, "R6 valid_o in reset", {31'b0, valid_o}, 32'h0);
      check(prod_o === 32'h0, "R6 prod_o in reset", prod_o, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1 slice split, example coefficient and each slice position alone
      send(16'h0001, 16'hADB6, "R1 example coef X=1");
      send(16'hFFFF, 16'hADB6, "R1 example coef X=-1");
      for (int j = 0; j < 4; j++) begin
         send(16'd777, 16'(16'h5 << (4 * j)), "R1 single slice 5");
         send(16'd1, 16'(16'h1 << (4 * j)), "R1 slice weight");
         send(16'hFC2E, 16'(16'h8 << (4 * j)), "R1 top value slice");
      end
      idle(1);

      // R2 every slice value 0..15 in low and high slice
      for (int k = 0; k < 16; k++) begin
         send(16'hFB2E, 16'(k), "R2 slice sweep low");
         send(16'd12345, 16'(k << 12), "R2 slice sweep high");
      end
      idle(3);

      // R7 extreme operands
      send(16'h8000, 16'hFFFF, "R7 min x max coef");
      send(16'h7FFF, 16'hFFFF, "R7 max x max coef");
      send(16'h8000, 16'h0000, "R7 zero coef");
      send(16'h0000, 16'hFFFF, "R7 zero x");
      send(16'hFFFF, 16'h0001, "R7 x=-1 coef=1");
      send(16'h8000, 16'h8000, "R7 min x top bit coef");
      idle(2);

      // R3 random pairs with R4/R5 gaps
      for (int n = 0; n < 400; n++) begin
         send(16'($urandom), 16'($urandom), "R3 random");
         if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
      end
      idle(4);

      // R4 every queued result must have arrived one cycle after its strobe
      check(exp_q.size() == 0, "R4 outstanding results", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule